// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This block resolves the control-transfer instructions of a 32-bit RISC pipeline in which every jump or branch has exactly one delay slot. Each issued instruction word is decoded together with its PC, the condition flag and the value read from the source register. For a jump or branch the block works out whether it is taken, the target address, and any return-address write. It then holds the target while the following instruction, the delay slot, issues. The fetch redirect comes out only after that delay-slot instruction has been accepted.

Six primary opcodes are recognised. There are four PC-relative forms: jump, jump-and-link, branch-if-flag-set and branch-if-flag-clear. There are two register-indirect forms: jump-to-register and jump-and-link-to-register. Opcodes that another unit claims pass through without effect. Every other opcode is reported as illegal. A branch issued inside the delay slot of another branch is also reported as illegal. A register target whose two low bits are not zero raises a misalignment flag. A flush discards the pending redirect.

Top module: `dbr_unit`

## Requirements
- R1: The primary opcode is insn[31:26]. The six control opcodes are: 0x00 jump, 0x01 jump-and-link, 0x03 branch-if-flag-clear, 0x04 branch-if-flag-set, 0x11 jump-to-register and 0x12 jump-and-link-to-register.
- R2: For the four PC-relative forms, insn[25:0] is a signed word offset. The target is the branch PC plus four times the sign-extended offset, modulo 2^32.
- R3: For the register forms, src_idx_o equals insn[15:11] combinationally, and the target is src_val_i. Bits 25:16 and 10:0 have no effect.
- R4: Branch-if-flag-set is taken when flag_i is 1. Branch-if-flag-clear is taken when flag_i is 0. A branch that is not taken never pulses redirect_o.
- R5: Both link forms pulse link_we_o for one cycle, in the cycle after issue. With that pulse, link_idx_o is 9 and link_data_o is the branch PC plus 8, even when the target equals PC+8.
- R6: A taken branch pulses redirect_o, with redirect_pc_o holding the target, in the cycle after the next accepted instruction. Cycles without an accepted instruction keep the target pending, and redirect_o stays low while the target waits.
- R7: An accepted instruction whose opcode is not one of the six, with other_claim_i low, pulses illegal_o in the cycle after issue. It arms no redirect. With other_claim_i high it produces no output at all.
- R8: A jump or branch accepted in a delay slot pulses illegal_o. It writes no link and arms nothing. The earlier branch's redirect still comes out with its own target in that same cycle.
- R9: While flush_i is high, issue_ready_o is low and no instruction is accepted. A flush clears any pending redirect, so the next accepted instruction produces no redirect.
- R10: A register-form branch whose target has insn-selected register value bits [1:0] nonzero pulses misalign_o in the cycle after issue. It never produces a redirect. Its link write still takes place.
- R11: After reset every output pulse is low, redirect_pc_o and link_data_o are zero, and issue_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard the pending redirect and refuse issue this cycle |
| issue_valid_i | input | 1 | An instruction is offered |
| issue_ready_o | output | 1 | The unit accepts the offered instruction |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 32 | PC of the instruction |
| flag_i | input | 1 | Condition flag |
| src_val_i | input | 32 | Value of the register selected by src_idx_o |
| other_claim_i | input | 1 | Another unit recognises this opcode |
| src_idx_o | output | 5 | Source register index for the register forms |
| link_we_o | output | 1 | Return-address write strobe |
| link_idx_o | output | 5 | Destination register of the return address (9) |
| link_data_o | output | 32 | Return address |
| redirect_o | output | 1 | Fetch redirect strobe after the delay slot |
| redirect_pc_o | output | 32 | Redirect target |
| illegal_o | output | 1 | Illegal instruction or branch in delay slot |
| misalign_o | output | 1 | Register target not word aligned |

## Verification
Two outputs can pulse in the same cycle: the redirect of a pending branch, and the illegal report for a second branch placed in its delay slot. The bench provokes this by issuing a jump and then a jump-and-link straight after it. In the cycle after that second issue it expects three things at once: redirect_o high with the first jump's target, illegal_o high, and no link write. The following cycle must show no further redirect, which proves the slot branch armed nothing.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_JMP, K_JMPL, K_BCLR, K_BSET, K_JREG, K_JREGL
  } br_kind_e;

  localparam logic [5:0] OPC_JMP   = 6'h00;
  localparam logic [5:0] OPC_JMPL  = 6'h01;
  localparam logic [5:0] OPC_BCLR  = 6'h03;
  localparam logic [5:0] OPC_BSET  = 6'h04;
  localparam logic [5:0] OPC_JREG  = 6'h11;
  localparam logic [5:0] OPC_JREGL = 6'h12;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OPC_W  = 6,
  parameter int OFF_W  = 26,
  parameter int RIDX_W = 5,
  parameter int RIDX_LSB = 11
) (
  input  logic [XLEN-1:0]   insn_i,
  output br_kind_e          kind_o,
  output logic              is_branch_o,
  output logic              is_link_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic [RIDX_W-1:0] src_idx_o
);
  localparam int OPC_LSB = XLEN - OPC_W;

  logic [OPC_W-1:0] opc;
  assign opc       = insn_i[XLEN-1:OPC_LSB];
  assign offset_o  = insn_i[OFF_W-1:0];
  assign src_idx_o = insn_i[RIDX_LSB +: RIDX_W];

  always_comb begin
    case (opc)
      OPC_JMP:   kind_o = K_JMP;
      OPC_JMPL:  kind_o = K_JMPL;
      OPC_BCLR:  kind_o = K_BCLR;
      OPC_BSET:  kind_o = K_BSET;
      OPC_JREG:  kind_o = K_JREG;
      OPC_JREGL: kind_o = K_JREGL;
      default:   kind_o = K_NONE;
    endcase
  end

  assign is_branch_o = (kind_o != K_NONE);
  assign is_link_o   = (kind_o == K_JMPL) || (kind_o == K_JREGL);
endmodule

// File: rtl/dbr_target.sv
module dbr_target
  import dbr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 26
) (
  input  br_kind_e         kind_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             flag_i,
  input  logic [XLEN-1:0]  src_val_i,
  output logic             taken_o,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic             misalign_o
);
  localparam int EXT_W = XLEN - OFF_W;
  localparam logic [XLEN-1:0] SLOT_SKIP = XLEN'(8);

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] rel_tgt;
  logic            reg_form;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    end else begin : g_trunc
      assign off_ext = offset_i[XLEN-1:0];
    end
  endgenerate

  assign rel_tgt     = pc_i + (off_ext << 2);
  assign reg_form    = (kind_i == K_JREG) || (kind_i == K_JREGL);
  assign target_o    = reg_form ? src_val_i : rel_tgt;
  assign link_data_o = pc_i + SLOT_SKIP;
  assign misalign_o  = reg_form && (src_val_i[1:0] != 2'b00);

  always_comb begin
    case (kind_i)
      K_BSET:  taken_o = flag_i;
      K_BCLR:  taken_o = ~flag_i;
      K_NONE:  taken_o = 1'b0;
      default: taken_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dbr_slot_ctrl.sv
module dbr_slot_ctrl #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            fire_i,
  input  logic            is_branch_i,
  input  logic            is_link_i,
  input  logic            other_claim_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] link_data_i,
  input  logic            misalign_i,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            illegal_o,
  output logic            misalign_o
);
  logic            pend_q, pend_d;
  logic            take_q, take_d;
  logic [XLEN-1:0] tgt_q, tgt_d;
  logic            arm;
  logic            redir_d, lwe_d, ill_d, mis_d;

  // next state
  always_comb begin
    arm    = fire_i && !pend_q && is_branch_i;
    pend_d = pend_q;
    take_d = take_q;
    tgt_d  = tgt_q;
    if (flush_i) begin
      pend_d = 1'b0;
      take_d = 1'b0;
    end else if (fire_i) begin
      pend_d = arm;
      take_d = arm && taken_i && !misalign_i;
      if (arm) tgt_d = target_i;
    end
    redir_d = fire_i && pend_q && take_q;
    lwe_d   = arm && is_link_i;
    ill_d   = fire_i && ((pend_q && is_branch_i) ||
                         (!is_branch_i && !other_claim_i));
    mis_d   = arm && misalign_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      take_q     <= 1'b0;
      tgt_q      <= '0;
      redirect_o <= 1'b0;
      link_we_o  <= 1'b0;
      illegal_o  <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      take_q     <= take_d;
      tgt_q      <= tgt_d;
      redirect_o <= redir_d;
      link_we_o  <= lwe_d;
      illegal_o  <= ill_d;
      misalign_o <= mis_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_pc_o <= '0;
    end else if (redir_d) begin
      redirect_pc_o <= tgt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_data_o <= '0;
    end else if (lwe_d) begin
      link_data_o <= link_data_i;
    end
  end

  a_r6_slot_then_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && pend_q && take_q) |=> redirect_o);

  a_r6_no_double_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> !$past(redirect_o));

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!redirect_o && !pend_q));

  a_r8_illegal_no_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !link_we_o);

  a_r10_misalign_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (pend_q && !take_q));
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit
  import dbr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OPC_W    = 6,
  parameter int OFF_W    = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [XLEN-1:0]   insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              flag_i,
  input  logic [XLEN-1:0]   src_val_i,
  input  logic              other_claim_i,
  output logic [RIDX_W-1:0] src_idx_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              illegal_o,
  output logic              misalign_o
);
  br_kind_e         kind;
  logic             is_branch, is_link, taken, mis;
  logic [OFF_W-1:0] offset;
  logic [XLEN-1:0]  target, ldata;
  logic             fire;

  assign issue_ready_o = ~flush_i;
  assign fire          = issue_valid_i && issue_ready_o;
  assign link_idx_o    = RIDX_W'(LINK_REG);

  dbr_decode #(.XLEN(XLEN), .OPC_W(OPC_W), .OFF_W(OFF_W), .RIDX_W(RIDX_W)) u_dec (
    .insn_i     (insn_i),
    .kind_o     (kind),
    .is_branch_o(is_branch),
    .is_link_o  (is_link),
    .offset_o   (offset),
    .src_idx_o  (src_idx_o)
  );

  dbr_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .kind_i     (kind),
    .offset_i   (offset),
    .pc_i       (pc_i),
    .flag_i     (flag_i),
    .src_val_i  (src_val_i),
    .taken_o    (taken),
    .target_o   (target),
    .link_data_o(ldata),
    .misalign_o (mis)
  );

  dbr_slot_ctrl #(.XLEN(XLEN)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .fire_i       (fire),
    .is_branch_i  (is_branch),
    .is_link_i    (is_link),
    .other_claim_i(other_claim_i),
    .taken_i      (taken),
    .target_i     (target),
    .link_data_i  (ldata),
    .misalign_i   (mis),
    .link_we_o    (link_we_o),
    .link_data_o  (link_data_o),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o),
    .illegal_o    (illegal_o),
    .misalign_o   (misalign_o)
  );
endmodule

// File: tb/dbr_unit_tb_top.sv
module dbr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, valid = 1'b0, flag = 1'b0, claim = 1'b0;
  logic [31:0] insn = '0, pc = '0, src = '0;
  logic ready, lwe, redir, ill, mis;
  logic [4:0] sidx, lidx;
  logic [31:0] ldata, rpc;
  int checks = 0, errs = 0;
  logic [4:0] seen_idx;

  always #2 clk = ~clk;

  dbr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .issue_valid_i(valid),
    .issue_ready_o(ready), .insn_i(insn), .pc_i(pc), .flag_i(flag),
    .src_val_i(src), .other_claim_i(claim), .src_idx_o(sidx),
    .link_we_o(lwe), .link_idx_o(lidx), .link_data_o(ldata),
    .redirect_o(redir), .redirect_pc_o(rpc), .illegal_o(ill), .misalign_o(mis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_imm(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction

  function automatic logic [31:0] mk_reg(input logic [5:0] op, input logic [4:0] r);
    return {op, 10'h2B6, r, 11'h4C9};
  endfunction

  // reference model
  function automatic logic [31:0] ref_tgt(input logic [31:0] w, input logic [31:0] p,
                                          input logic [31:0] s);
    if (w[31:26] == 6'h11 || w[31:26] == 6'h12) return s;
    return p + {{4{w[25]}}, w[25:0], 2'b00};
  endfunction

  function automatic logic ref_taken(input logic [31:0] w, input logic f);
    case (w[31:26])
      6'h03: return !f;
      6'h04: return f;
      default: return 1'b1;
    endcase
  endfunction

  task automatic issue(input logic [31:0] w, input logic [31:0] p, input logic f,
                       input logic [31:0] s, input logic c);
    @(negedge clk);
    valid = 1'b1; insn = w; pc = p; flag = f; src = s; claim = c;
    #1 seen_idx = sidx;
    @(posedge clk);
    #1 valid = 1'b0;
  endtask

  task automatic filler(input logic [31:0] p);
    issue({6'h05, 26'h0}, p, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic run_branch(input logic [31:0] w, input logic [31:0] p, input logic f,
                            input logic [31:0] s);
    logic is_lk, is_rg, exp_mis, exp_red;
    is_lk   = (w[31:26] == 6'h01) || (w[31:26] == 6'h12);
    is_rg   = (w[31:26] == 6'h11) || (w[31:26] == 6'h12);
    exp_mis = is_rg && (s[1:0] != 2'b00);
    exp_red = ref_taken(w, f) && !exp_mis;
    issue(w, p, f, s, 1'b0);
    if (is_rg) chk("R3 src index", {27'h0, seen_idx}, {27'h0, w[15:11]});
    chk("R1 no illegal for control opcode", {31'h0, ill}, 32'h0);
    chk("R6 no redirect at issue", {31'h0, redir}, 32'h0);
    chk("R5 link strobe", {31'h0, lwe}, {31'h0, is_lk});
    if (is_lk) begin
      chk("R5 link data", ldata, p + 32'd8);
      chk("R5 link index", {27'h0, lidx}, 32'd9);
    end
    chk("R10 misalign", {31'h0, mis}, {31'h0, exp_mis});
    filler(p + 32'd4);
    chk("R4 R6 redirect after slot", {31'h0, redir}, {31'h0, exp_red});
    if (exp_red) chk("R2 R3 target", rpc, ref_tgt(w, p, s));
  endtask

  task automatic t_reset;
    chk("R11 ready", {31'h0, ready}, 32'h1);
    chk("R11 pulses", {27'h0, lwe, redir, ill, mis, 1'b0}, 32'h0);
    chk("R11 redirect pc", rpc, 32'h0);
    chk("R11 link data", ldata, 32'h0);
  endtask

  task automatic t_relative;
    run_branch(mk_imm(6'h00, 26'h1FFFFFF), 32'h1000_0000, 1'b0, 32'h0); // R2 max +
    run_branch(mk_imm(6'h00, 26'h2000000), 32'h1000_0000, 1'b0, 32'h0); // R2 max -
    run_branch(mk_imm(6'h01, 26'h0000010), 32'h0000_4000, 1'b0, 32'h0);
    run_branch(mk_imm(6'h01, 26'h0000002), 32'h0000_5000, 1'b0, 32'h0); // R5 tgt=PC+8
    chk("R2 value check", ref_tgt(mk_imm(6'h00, 26'h2000000), 32'h1000_0000, 0), 32'h0800_0000);
  endtask

  task automatic t_conditional;
    run_branch(mk_imm(6'h04, 26'h3FFFFF0), 32'h0000_8000, 1'b1, 32'h0); // R4 set, f=1
    run_branch(mk_imm(6'h04, 26'h0000020), 32'h0000_8100, 1'b0, 32'h0); // R4 set, f=0
    run_branch(mk_imm(6'h03, 26'h0000030), 32'h0000_8200, 1'b0, 32'h0); // R4 clr, f=0
    run_branch(mk_imm(6'h03, 26'h0000040), 32'h0000_8300, 1'b1, 32'h0); // R4 clr, f=1
  endtask

  task automatic t_register;
    run_branch(mk_reg(6'h11, 5'd7),  32'h0000_9000, 1'b0, 32'hDEAD_BEE0);
    run_branch(mk_reg(6'h12, 5'd30), 32'h0000_9100, 1'b1, 32'h1234_5678);
    run_branch(mk_reg(6'h12, 5'd3),  32'h0000_9200, 1'b0, 32'h0000_3002); // R10
    run_branch(mk_reg(6'h11, 5'd1),  32'h0000_9300, 1'b0, 32'h0000_3001); // R10
  endtask

  task automatic t_pending_hold;
    issue(mk_reg(6'h11, 5'd4), 32'h0000_2000, 1'b0, 32'h8000_0010, 1'b0);
    repeat (2) begin
      @(posedge clk); #1;
      chk("R6 held while idle", {31'h0, redir}, 32'h0);
    end
    filler(32'h0000_2004);
    chk("R6 redirect after gap", {31'h0, redir}, 32'h1);
    chk("R6 target after gap", rpc, 32'h8000_0010);
  endtask

  task automatic t_illegal;
    issue({6'h3F, 26'h0}, 32'h0000_A000, 1'b0, 0, 1'b0);
    chk("R7 illegal opcode", {31'h0, ill}, 32'h1);
    chk("R7 no link", {31'h0, lwe}, 32'h0);
    filler(32'h0000_A004);
    chk("R7 no redirect", {31'h0, redir}, 32'h0);
    chk("R7 claimed opcode not illegal", {31'h0, ill}, 32'h0);
  endtask

  task automatic t_slot_branch;
    issue(mk_imm(6'h00, 26'h0000010), 32'h0000_1000, 1'b0, 0, 1'b0);
    issue(mk_imm(6'h01, 26'h0000100), 32'h0000_1004, 1'b0, 0, 1'b0);
    chk("R8 illegal in slot", {31'h0, ill}, 32'h1);
    chk("R8 redirect same cycle", {31'h0, redir}, 32'h1);
    chk("R8 first target kept", rpc, 32'h0000_1040);
    chk("R8 no link in slot", {31'h0, lwe}, 32'h0);
    filler(32'h0000_1008);
    chk("R8 slot branch not armed", {31'h0, redir}, 32'h0);
  endtask

  task automatic t_flush;
    issue(mk_imm(6'h00, 26'h0000008), 32'h0000_B000, 1'b0, 0, 1'b0);
    @(negedge clk);
    flush = 1'b1;
    #1 chk("R9 ready low in flush", {31'h0, ready}, 32'h0);
    @(posedge clk);
    #1 flush = 1'b0;
    filler(32'h0000_B004);
    chk("R9 flushed redirect gone", {31'h0, redir}, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset;
    @(negedge clk) rst_n = 1'b1;
    t_relative;
    t_conditional;
    t_register;
    t_pending_hold;
    t_illegal;
    t_slot_branch;
    t_flush;
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule